// File: doc/BRIEF.md
# Microsequencer with One-Level Subroutine Return

This block is a microprogrammed control unit that steps through an internal 16-word control store. Each word is 8 bits wide. It drives two active-low control lines and a 2-bit code that picks where the next microaddress comes from. There are four sources for that address: the word's own jump field, an address mapped from a 2-bit opcode, a saved return address, or a call. A call jumps to the jump field and saves the address that follows it. The next address is resolved combinationally, so every microinstruction takes exactly one clock.

A four-step fetch routine keeps both control lines inactive. Its last step dispatches on the opcode. Two instruction routines are provided. Each one runs three steps, then calls a shared one-step subroutine that drives both lines, and then resumes at a closing step that returns to fetch. The return register holds only one address, so calls cannot be nested.

Top module: `mseq_sub_top`

## Requirements
- R1: A synchronous reset clears the microaddress register and the return register to 0, so the first step after reset is fetch address 0.
- R2: The control word is laid out as bits [7:6] next-address select, bit [5] Z2 (active low), bit [4] Z3 (active low), and bits [3:0] jump field. The outputs z2_n and z3_n come directly from the word at the current microaddress.
- R3: Select code 00 makes the jump field the next microaddress.
- R4: Select code 01 makes the mapped address the next microaddress. Opcode 01 maps to 4, opcode 10 maps to 8, and opcodes 00 and 11 map back to fetch address 0.
- R5: Select code 11 is a call. The next microaddress is the jump field, and the return register loads the current microaddress plus one in the same clock.
- R6: Select code 10 is a return. The next microaddress is the return register's contents, with no added cycle.
- R7: Fetch occupies addresses 0 to 3 and holds z2_n and z3_n high on all four steps. Address 3 selects the mapped address.
- R8: With opcode 01, the microaddress runs 0,1,2,3,4,5,6,12,7,0. The active lines on addresses 4, 5 and 6 are Z2, then Z3, then none. Subroutine address 12 drives Z2 and Z3. The resume step at 7 drives none.
- R9: With opcode 10, the microaddress runs 0,1,2,3,8,9,10,12,11,0. The active lines are Z3, then Z2, then Z2 and Z3, then Z2 and Z3 at the subroutine. The resume step at 11 drives none.
- R10: The opcode is used only on the last fetch step. Changing it while an instruction routine runs has no effect on the sequence.
- R11: The return register keeps its value on every step that is not a call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock; one microinstruction per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 2 | Instruction opcode consulted at the dispatch step |
| upc | output | 4 | Current microaddress |
| z2_n | output | 1 | Control line Z2, active low |
| z3_n | output | 1 | Control line Z3, active low |

## Verification
The bench builds the block with its default widths: a 4-bit microaddress and a 2-bit opcode. These values cover the whole 16-word store and all four opcodes, including the two that loop back to fetch. A vector table follows both instruction routines through their calls and returns, cycle by cycle. Directed runs then change the opcode in the middle of a routine and apply reset while the subroutine step is executing.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int MS_AW = 4;
  localparam int MS_OW = 2;
  localparam int MS_CW = MS_AW + 4;

  typedef enum logic [1:0] {
    SEL_JUMP = 2'b00,
    SEL_MAP  = 2'b01,
    SEL_RET  = 2'b10,
    SEL_CALL = 2'b11
  } nsel_e;

  typedef struct packed {
    nsel_e             sel;
    logic              z2_n;
    logic              z3_n;
    logic [MS_AW-1:0]  jump;
  } uword_t;

  localparam logic [MS_AW-1:0] A_FETCH      = MS_AW'(0);
  localparam logic [MS_AW-1:0] A_FETCH_LAST = MS_AW'(3);
  localparam logic [MS_AW-1:0] A_OP1        = MS_AW'(4);
  localparam logic [MS_AW-1:0] A_OP2        = MS_AW'(8);
  localparam logic [MS_AW-1:0] A_SUB        = MS_AW'(12);

  function automatic logic [MS_AW-1:0] addr_inc(input logic [MS_AW-1:0] a);
    return a + MS_AW'(1);
  endfunction

  function automatic logic [MS_AW-1:0] map_opcode(input logic [MS_OW-1:0] opc);
    case (opc)
      2'b01:   return A_OP1;
      2'b10:   return A_OP2;
      default: return A_FETCH;
    endcase
  endfunction

  function automatic uword_t mk(input nsel_e s, input logic z2n, input logic z3n,
                                input logic [MS_AW-1:0] j);
    uword_t w;
    w.sel  = s;
    w.z2_n = z2n;
    w.z3_n = z3n;
    w.jump = j;
    return w;
  endfunction

  // Control store contents, computed from the layout addresses above.
  function automatic uword_t rom_word(input logic [MS_AW-1:0] a);
    uword_t w;
    w = mk(SEL_JUMP, 1'b1, 1'b1, A_FETCH);          // unused words fall back to fetch
    if (a < A_FETCH_LAST)        w = mk(SEL_JUMP, 1'b1, 1'b1, addr_inc(a));
    else if (a == A_FETCH_LAST)  w = mk(SEL_MAP,  1'b1, 1'b1, A_FETCH);
    else if (a == A_OP1)         w = mk(SEL_JUMP, 1'b0, 1'b1, addr_inc(a));
    else if (a == A_OP1 + 1)     w = mk(SEL_JUMP, 1'b1, 1'b0, addr_inc(a));
    else if (a == A_OP1 + 2)     w = mk(SEL_CALL, 1'b1, 1'b1, A_SUB);
    else if (a == A_OP1 + 3)     w = mk(SEL_JUMP, 1'b1, 1'b1, A_FETCH);
    else if (a == A_OP2)         w = mk(SEL_JUMP, 1'b1, 1'b0, addr_inc(a));
    else if (a == A_OP2 + 1)     w = mk(SEL_JUMP, 1'b0, 1'b1, addr_inc(a));
    else if (a == A_OP2 + 2)     w = mk(SEL_CALL, 1'b0, 1'b0, A_SUB);
    else if (a == A_OP2 + 3)     w = mk(SEL_JUMP, 1'b1, 1'b1, A_FETCH);
    else if (a == A_SUB)         w = mk(SEL_RET,  1'b0, 1'b0, A_FETCH);
    return w;
  endfunction
endpackage

// File: rtl/mseq_ctrl_store.sv
module mseq_ctrl_store
  import mseq_pkg::*;
#(
  parameter int AW = MS_AW
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  always_comb word = rom_word(addr);
endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
  import mseq_pkg::*;
#(
  parameter int AW = MS_AW,
  parameter int OW = MS_OW
) (
  input  logic [AW-1:0] upc,
  input  nsel_e         sel,
  input  logic [AW-1:0] jump,
  input  logic [OW-1:0] opcode,
  input  logic [AW-1:0] ret_q,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] ret_d,
  output logic          do_call,
  output logic          do_ret
);
  always_comb begin
    unique case (sel)
      SEL_JUMP: nxt = jump;
      SEL_MAP:  nxt = map_opcode(opcode);
      SEL_RET:  nxt = ret_q;
      SEL_CALL: nxt = jump;
      default:  nxt = jump;
    endcase
  end

  assign ret_d   = addr_inc(upc);
  assign do_call = (sel == SEL_CALL);
  assign do_ret  = (sel == SEL_RET);
endmodule

// File: rtl/mseq_ret_reg.sv
module mseq_ret_reg #(
  parameter int AW = mseq_pkg::MS_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R1: reset clears the return register
  p_ret_clear_r1: assert property (@(posedge clk) rst |=> (q == '0));
  // R11: no call, no change
  p_ret_hold_r11: assert property (@(posedge clk) disable iff (rst)
                                   !load |=> $stable(q));
  // R5: call captures the supplied return address
  p_ret_load_r5:  assert property (@(posedge clk) disable iff (rst)
                                   load |=> (q == $past(d)));
endmodule

// File: rtl/mseq_sub_top.sv
module mseq_sub_top
  import mseq_pkg::*;
#(
  parameter int AW = MS_AW,
  parameter int OW = MS_OW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] upc,
  output logic          z2_n,
  output logic          z3_n
);
  uword_t        word;
  logic [AW-1:0] nxt;
  logic [AW-1:0] ret_d;
  logic [AW-1:0] ret_q;
  logic          do_call;
  logic          do_ret;

  mseq_ctrl_store #(.AW(AW)) u_store (
    .addr (upc),
    .word (word)
  );

  mseq_next_addr #(.AW(AW), .OW(OW)) u_next (
    .upc     (upc),
    .sel     (word.sel),
    .jump    (word.jump),
    .opcode  (opcode),
    .ret_q   (ret_q),
    .nxt     (nxt),
    .ret_d   (ret_d),
    .do_call (do_call),
    .do_ret  (do_ret)
  );

  mseq_ret_reg #(.AW(AW)) u_ret (
    .clk  (clk),
    .rst  (rst),
    .load (do_call),
    .d    (ret_d),
    .q    (ret_q)
  );

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= nxt;
  end

  assign z2_n = word.z2_n;
  assign z3_n = word.z3_n;

  // R1: reset lands on fetch
  p_reset_r1: assert property (@(posedge clk) rst |=> (upc == A_FETCH));
  // R3: plain jump follows the jump field
  p_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (word.sel == SEL_JUMP) |=> (upc == $past(word.jump)));
  // R4: opcodes 00 and 11 loop back to fetch
  p_map_bad_r4: assert property (@(posedge clk) disable iff (rst)
    ((word.sel == SEL_MAP) && (opcode == 2'b00 || opcode == 2'b11)) |=> (upc == A_FETCH));
  // R5: call goes to the jump field and saves the following address
  p_call_r5: assert property (@(posedge clk) disable iff (rst)
    do_call |=> ((upc == $past(word.jump)) && (ret_q == addr_inc($past(upc)))));
  // R6: return takes the saved address in one step
  p_ret_path_r6: assert property (@(posedge clk) disable iff (rst)
    do_ret |=> (upc == $past(ret_q)));
  // R7: fetch keeps both lines inactive
  p_fetch_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (upc <= A_FETCH_LAST) |-> (z2_n && z3_n));
endmodule

// File: tb/test_mseq_sub_top.sv
module test_mseq_sub_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] opcode = 2'b00;
  logic [3:0] upc;
  logic       z2_n, z3_n;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  mseq_sub_top i_mseq_sub_top (
    .clk(clk), .rst(rst), .opcode(opcode),
    .upc(upc), .z2_n(z2_n), .z3_n(z3_n)
  );

  // Row: {opcode[7:6], expected upc[5:2], z2_n[1], z3_n[0]}
  // Encodings (R2): active-low lines; sequencing uses select codes from R3..R6.
  localparam int NROWS = 27;
  localparam logic [7:0] ROWS [NROWS] = '{
    // opcode 01 (R8): fetch, 4,5,6, call to 12 (R5), return to 7 (R6), jump 0 (R3)
    8'b01_0000_11, 8'b01_0001_11, 8'b01_0010_11, 8'b01_0011_11,
    8'b01_0100_01, 8'b01_0101_10, 8'b01_0110_11, 8'b01_1100_00, 8'b01_0111_11,
    // opcode 10 (R9)
    8'b10_0000_11, 8'b10_0001_11, 8'b10_0010_11, 8'b10_0011_11,
    8'b10_1000_10, 8'b10_1001_01, 8'b10_1010_00, 8'b10_1100_00, 8'b10_1011_11,
    // opcode 00 and 11 map back to fetch (R4, R7)
    8'b00_0000_11, 8'b00_0001_11, 8'b00_0010_11, 8'b00_0011_11,
    8'b11_0000_11, 8'b11_0001_11, 8'b11_0010_11, 8'b11_0011_11,
    8'b01_0000_11
  };

  task automatic chk(input string req, input logic [3:0] ue, input logic z2e, input logic z3e);
    n_chk++;
    if (upc !== ue || z2_n !== z2e || z3_n !== z3e) begin
      n_bad++;
      $display("FAIL %s: upc=%0d z2_n=%b z3_n=%b expected upc=%0d z2_n=%b z3_n=%b",
               req, upc, z2_n, z3_n, ue, z2e, z3e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  function automatic string row_tag(input logic [1:0] o);
    if (o == 2'b01) return "R8";
    if (o == 2'b10) return "R9";
    return "R4";
  endfunction

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1", 4'd0, 1'b1, 1'b1);

    for (int i = 0; i < NROWS; i++) begin
      opcode = ROWS[i][7:6];
      chk(row_tag(ROWS[i][7:6]), ROWS[i][5:2], ROWS[i][1], ROWS[i][0]);
      @(negedge clk);
    end

    // R10: opcode changes after dispatch are ignored
    do_reset();
    opcode = 2'b01;
    for (int k = 0; k < 4; k++) @(negedge clk);
    opcode = 2'b10;
    chk("R10", 4'd4, 1'b0, 1'b1);
    @(negedge clk); opcode = 2'b11; chk("R10", 4'd5, 1'b1, 1'b0);
    @(negedge clk); opcode = 2'b00; chk("R10", 4'd6, 1'b1, 1'b1);
    @(negedge clk); chk("R10", 4'd12, 1'b0, 1'b0);
    @(negedge clk); chk("R10", 4'd7, 1'b1, 1'b1);   // R11: saved 7 still held
    @(negedge clk); chk("R10", 4'd0, 1'b1, 1'b1);

    // R1: reset applied during the subroutine step
    opcode = 2'b10;
    for (int k = 0; k < 7; k++) @(negedge clk);
    chk("R6", 4'd12, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", 4'd0, 1'b1, 1'b1);
    rst = 1'b0;
    @(negedge clk); chk("R1", 4'd1, 1'b1, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule